// File: doc/BRIEF.md
# Two-Level Microcode/Nanocode Control Sequencer

This block is the control unit of a small processor. It keeps control information in two stores. A narrow microcode store holds next-address control, an encoded 4-bit register-read field and a pointer. The pointer indexes a wide nanocode store. Each nanoword is an unencoded control vector: one enable bit per register and an ALU select. Many microwords may point at the same nanoword, so a common control pattern is stored only once.

Each instruction starts with the decode of one opcode from the prefetch queue. The decoder produces two entry points: one for the addressing-mode (effective address) routine and one for the operation routine. The sequencer runs the effective-address routine. When that routine ends, the sequencer jumps to the saved operation entry. Microwords can step, jump, or branch on one selected condition flag. When the operation routine ends, the sequencer returns to the instruction boundary.

At the boundary a pending interrupt takes priority and vectors the sequencer to a fixed entry microaddress. Otherwise the sequencer takes the next opcode from the queue. The nanocode read is registered, so control vectors follow the microaddress by one cycle.

The sequencer has three named states:
- FETCH is the instruction boundary.
- EA runs the effective-address routine.
- OP runs the operation or interrupt routine.

It has these named transitions:
- FETCH→OP (interrupt accept)
- FETCH→EA (opcode pop)
- EA→OP (end of the effective-address routine)
- OP→FETCH (end of instruction)
- holding in FETCH when idle

Top module: `mnseq_top`

## Requirements
- R1: After reset the sequencer is in FETCH, `uaddr` is 0, and `reg_en`, `alu_sel` and `rd_sel` are all zero.
- R2: In FETCH with `q_valid` high and `irq_pend` low, `q_pop` is high in that same cycle. In the next cycle `uaddr` holds the mode entry picked by opcode bits [7:6]: 0→1, 1→2, 2→4, 3→8.
- R3: The end of the effective-address routine moves `uaddr` to the operation entry 16+4×opcode[2:0]. Opcode bits [5:3] have no effect on any output.
- R4: A sequential microword (next-control code 0) advances `uaddr` by one. A jump (code 1) loads its target. In the example program, word 4 jumps to 6.
- R5: A conditional microword (code 2) loads its target when `cond_flags[sel]` is 1 and advances by one otherwise. Word 8 tests bit 0 and targets 10. Word 44 tests bit 2 and targets 47.
- R6: One cycle after `uaddr` = a while executing, the outputs are as follows, with p = a mod 32 being the microword's nanoword pointer. `reg_en` = 1<<(p mod 16) and `alu_sel` = {p[4],p[2:0]}. Both are zero when p = 0. In the cycle after a FETCH cycle, both are zero.
- R7: In the same cycle as R6, `rd_sel` is the one-hot decode of the microword's 4-bit register field, which equals a[3:0] in the example program. It is zero after FETCH.
- R8: Microwords sharing one nanoword pointer (16 and 48) give identical `reg_en` and `alu_sel`.
- R9: In FETCH with `irq_pend` high, `irq_ack` is high and `q_pop` low, even when `q_valid` is high. The next `uaddr` is 48. The interrupt routine runs 48, 49 and then returns to FETCH.
- R10: An interrupt raised during EA or OP is not acknowledged until the instruction's final microword has executed. It is then taken at the next FETCH.
- R11: Outside FETCH `q_pop` stays low. In FETCH with no request pending, the sequencer holds with `uaddr` 0 and zero controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Prefetch queue holds an opcode |
| q_opcode | input | 8 | Opcode at the queue head |
| q_pop | output | 1 | Opcode taken this cycle |
| irq_pend | input | 1 | Interrupt pending |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| cond_flags | input | 4 | Condition flags for branches |
| uaddr | output | 6 | Current microaddress (0 in FETCH) |
| reg_en | output | 16 | Horizontal register enables |
| alu_sel | output | 4 | ALU function select |
| rd_sel | output | 16 | Decoded register-read select |

## Verification
`q_pop` and `irq_ack` are combinational from the FETCH state and the request inputs. They are checked one time unit after the inputs change in a FETCH cycle. `uaddr` changes one clock edge after a pop, an acknowledge or a microword, so the bench compares it at each following falling edge against the routine's expected path. The control vectors come one edge later still. At every falling edge the bench checks them against the microaddress it saw one edge earlier, and one extra edge is checked after the return to FETCH to confirm they clear.

// File: rtl/mnseq_pkg.sv
package mnseq_pkg;

    parameter int UA_W   = 6;
    parameter int NA_W   = 5;
    parameter int RS_W   = 4;
    parameter int NREG   = 16;
    parameter int ALU_W  = 4;
    parameter int FSEL_W = 2;
    localparam int UDEPTH = 1 << UA_W;
    localparam int NDEPTH = 1 << NA_W;
    localparam int NW     = NREG + ALU_W;

    typedef enum logic [1:0] {
        NX_SEQ  = 2'd0,
        NX_JMP  = 2'd1,
        NX_CJMP = 2'd2,
        NX_END  = 2'd3
    } nxt_e;

    typedef struct packed {
        nxt_e               nxt;
        logic [FSEL_W-1:0]  fsel;
        logic [UA_W-1:0]    tgt;
        logic [NA_W-1:0]    nptr;
        logic [RS_W-1:0]    rsel;
    } uword_t;

    localparam int UW = $bits(uword_t);

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EA    = 2'd1,
        ST_OP    = 2'd2
    } seq_state_e;

    // Example microprogram; every word points at nanoword (addr mod 32)
    // and selects register addr[3:0]. Unlisted words end the routine.
    function automatic logic [UDEPTH*UW-1:0] build_urom();
        logic [UDEPTH*UW-1:0] img;
        uword_t w;
        img = '0;
        for (int a = 0; a < UDEPTH; a++) begin
            w.nxt  = NX_END;
            w.fsel = '0;
            w.tgt  = '0;
            w.nptr = NA_W'(a);
            w.rsel = RS_W'(a);
            if (a == 2 || a == 5 || a == 45 || a == 48) w.nxt = NX_SEQ;
            if (a == 4) begin
                w.nxt = NX_JMP;
                w.tgt = UA_W'(6);
            end
            if (a == 8) begin
                w.nxt  = NX_CJMP;
                w.fsel = FSEL_W'(0);
                w.tgt  = UA_W'(10);
            end
            if (a == 44) begin
                w.nxt  = NX_CJMP;
                w.fsel = FSEL_W'(2);
                w.tgt  = UA_W'(47);
            end
            if (a >= 16 && a < 44 && (a % 4) == 0) w.nxt = NX_SEQ;
            img[a*UW +: UW] = w;
        end
        return img;
    endfunction

    // Nanoword p: one-hot enable of register p mod 16, ALU select
    // {p[4],p[2:0]}; pointer 0 is the all-zero no-operation word.
    function automatic logic [NDEPTH*NW-1:0] build_nrom();
        logic [NDEPTH*NW-1:0] img;
        logic [NW-1:0] w;
        logic [NA_W-1:0] pb;
        img = '0;
        for (int p = 1; p < NDEPTH; p++) begin
            pb = NA_W'(p);
            w = '0;
            w[NW-1 -: NREG] = NREG'(1) << (p % NREG);
            w[ALU_W-1:0]    = {pb[NA_W-1], pb[ALU_W-2:0]};
            img[p*NW +: NW] = w;
        end
        return img;
    endfunction

endpackage

// File: rtl/mnseq_opdec.sv
module mnseq_opdec #(
    parameter int OPC_W     = 8,
    parameter int UA_W      = 6,
    parameter int MODE_W    = 2,
    parameter int OPS_W     = 3,
    parameter logic [(1<<MODE_W)*UA_W-1:0] EA_TAB = {6'd8, 6'd4, 6'd2, 6'd1},
    parameter int OP_BASE   = 16,
    parameter int OP_STRIDE = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  ea_start,
    output logic [UA_W-1:0]  op_start
);
    logic [MODE_W-1:0] mode;
    logic [OPS_W-1:0]  opk;
    logic              unused_mid;

    assign mode       = opcode[OPC_W-1 -: MODE_W];
    assign opk        = opcode[OPS_W-1:0];
    assign unused_mid = ^opcode[OPC_W-MODE_W-1:OPS_W];

    assign ea_start = EA_TAB[int'(mode)*UA_W +: UA_W];
    assign op_start = UA_W'(OP_BASE + OP_STRIDE * int'(opk));

endmodule

// File: rtl/mnseq_urom.sv
module mnseq_urom
    import mnseq_pkg::*;
#(
    parameter logic [UDEPTH*UW-1:0] INIT = build_urom()
) (
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    assign word = uword_t'(INIT[int'(addr)*UW +: UW]);
endmodule

// File: rtl/mnseq_nstage.sv
module mnseq_nstage
    import mnseq_pkg::*;
#(
    parameter logic [NDEPTH*NW-1:0] INIT = build_nrom()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [NA_W-1:0]  nptr,
    input  logic [RS_W-1:0]  rsel,
    output logic [NREG-1:0]  reg_en,
    output logic [ALU_W-1:0] alu_sel,
    output logic [NREG-1:0]  rd_sel
);
    logic [NW-1:0]   nword;
    logic [NREG-1:0] rs_dec;

    assign nword = INIT[int'(nptr)*NW +: NW];

    for (genvar g = 0; g < NREG; g++) begin : g_rsdec
        assign rs_dec[g] = (rsel == RS_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_en  <= '0;
            alu_sel <= '0;
            rd_sel  <= '0;
        end else if (active) begin
            reg_en  <= nword[NW-1 -: NREG];
            alu_sel <= nword[ALU_W-1:0];
            rd_sel  <= rs_dec;
        end else begin
            reg_en  <= '0;
            alu_sel <= '0;
            rd_sel  <= '0;
        end
    end

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (reg_en == '0 && alu_sel == '0));

    assert_rdsel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));

endmodule

// File: rtl/mnseq_top.sv
module mnseq_top
    import mnseq_pkg::*;
#(
    parameter int OPC_W     = 8,
    parameter int FLAG_W    = 1 << FSEL_W,
    parameter int IRQ_ENTRY = 48,
    parameter logic [UDEPTH*UW-1:0] UROM_INIT = build_urom(),
    parameter logic [NDEPTH*NW-1:0] NROM_INIT = build_nrom()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [OPC_W-1:0]  q_opcode,
    output logic              q_pop,
    input  logic              irq_pend,
    output logic              irq_ack,
    input  logic [FLAG_W-1:0] cond_flags,
    output logic [UA_W-1:0]   uaddr,
    output logic [NREG-1:0]   reg_en,
    output logic [ALU_W-1:0]  alu_sel,
    output logic [NREG-1:0]   rd_sel
);
    seq_state_e      state, state_n;
    logic [UA_W-1:0] upc, upc_n;
    logic [UA_W-1:0] opst, opst_n;
    logic [UA_W-1:0] ea_start, op_start;
    logic [UA_W-1:0] upc_inc;
    logic            exec;
    logic            flag_hit;
    uword_t          uw;

    mnseq_opdec #(.OPC_W(OPC_W), .UA_W(UA_W)) u_dec (
        .opcode   (q_opcode),
        .ea_start (ea_start),
        .op_start (op_start)
    );

    mnseq_urom #(.INIT(UROM_INIT)) u_urom (
        .addr (upc),
        .word (uw)
    );

    mnseq_nstage #(.INIT(NROM_INIT)) u_nano (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (exec),
        .nptr    (uw.nptr),
        .rsel    (uw.rsel),
        .reg_en  (reg_en),
        .alu_sel (alu_sel),
        .rd_sel  (rd_sel)
    );

    assign exec     = (state != ST_FETCH);
    assign upc_inc  = UA_W'(upc + 1'b1);
    assign flag_hit = cond_flags[uw.fsel];
    assign uaddr    = upc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            upc   <= '0;
            opst  <= '0;
        end else begin
            state <= state_n;
            upc   <= upc_n;
            opst  <= opst_n;
        end
    end

    // Next state and next microaddress
    always_comb begin
        state_n = state;
        upc_n   = upc;
        opst_n  = opst;
        unique case (state)
            ST_FETCH: begin
                if (irq_pend) begin
                    upc_n   = UA_W'(IRQ_ENTRY);
                    state_n = ST_OP;
                end else if (q_valid) begin
                    upc_n   = ea_start;
                    opst_n  = op_start;
                    state_n = ST_EA;
                end
            end
            ST_EA, ST_OP: begin
                unique case (uw.nxt)
                    NX_SEQ:  upc_n = upc_inc;
                    NX_JMP:  upc_n = uw.tgt;
                    NX_CJMP: upc_n = flag_hit ? uw.tgt : upc_inc;
                    NX_END: begin
                        if (state == ST_EA) begin
                            upc_n   = opst;
                            state_n = ST_OP;
                        end else begin
                            upc_n   = '0;
                            state_n = ST_FETCH;
                        end
                    end
                endcase
            end
            default: begin
                upc_n   = '0;
                state_n = ST_FETCH;
            end
        endcase
    end

    // Boundary handshake outputs
    always_comb begin
        q_pop   = 1'b0;
        irq_ack = 1'b0;
        unique case (state)
            ST_FETCH: begin
                irq_ack = irq_pend;
                q_pop   = q_valid && !irq_pend;
            end
            default: begin
                q_pop   = 1'b0;
                irq_ack = 1'b0;
            end
        endcase
    end

    assert_pop_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> q_valid);

    assert_cjmp_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && uw.nxt == NX_CJMP && cond_flags[uw.fsel]) |=> (uaddr == $past(uw.tgt)));

    assert_irq_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (uaddr == UA_W'(IRQ_ENTRY)));

    assert_ack_pop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && q_pop));

    assert_no_mid_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> (!irq_ack && !q_pop));

endmodule

// File: tb/tb_mnseq_top.sv
module tb_mnseq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        q_valid;
    logic [7:0]  q_opcode;
    logic        q_pop;
    logic        irq_pend;
    logic        irq_ack;
    logic [3:0]  cond_flags;
    logic [5:0]  uaddr;
    logic [15:0] reg_en;
    logic [3:0]  alu_sel;
    logic [15:0] rd_sel;

    int total = 0;
    int bad   = 0;
    logic [15:0] en16, en48;
    logic [3:0]  al16, al48;

    always #4 clk = ~clk;

    mnseq_top dut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_opcode(q_opcode),
        .q_pop(q_pop), .irq_pend(irq_pend), .irq_ack(irq_ack),
        .cond_flags(cond_flags), .uaddr(uaddr), .reg_en(reg_en),
        .alu_sel(alu_sel), .rd_sel(rd_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_en(input int a);
        int p = a % 32;
        return (p == 0) ? 16'h0 : (16'h1 << (p % 16));
    endfunction

    function automatic logic [3:0] exp_alu(input int a);
        logic [4:0] p = 5'(a % 32);
        return (p == 0) ? 4'h0 : {p[4], p[2:0]};
    endfunction

    task automatic check_ctl(input string tag, input int a);
        check({tag, " R6 reg_en"}, 32'(reg_en), 32'(exp_en(a)));
        check({tag, " R6 alu_sel"}, 32'(alu_sel), 32'(exp_alu(a)));
        check({tag, " R7 rd_sel"}, 32'(rd_sel), 32'(16'h1 << (a % 16)));
    endtask

    task automatic check_zero(input string tag);
        check({tag, " R6 zero reg_en"}, 32'(reg_en), 32'h0);
        check({tag, " R6 zero alu_sel"}, 32'(alu_sel), 32'h0);
        check({tag, " R7 zero rd_sel"}, 32'(rd_sel), 32'h0);
    endtask

    // Follow a microaddress path, checking controls one cycle behind.
    task automatic follow(input string tag, input int seq[4], input int n);
        check({tag, " first uaddr"}, 32'(uaddr), 32'(seq[0]));
        check({tag, " R11 no pop"}, 32'(q_pop), 32'h0);
        for (int i = 1; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            check({tag, " uaddr step"}, 32'(uaddr), 32'(seq[i]));
            check({tag, " R11 no pop"}, 32'(q_pop), 32'h0);
            check_ctl(tag, seq[i-1]);
        end
        @(posedge clk); @(negedge clk);
        check_ctl(tag, seq[n-1]);
        check({tag, " back to fetch"}, 32'(uaddr), 32'h0);
        @(posedge clk); @(negedge clk);
        check_zero(tag);
    endtask

    task automatic run_instr(input string tag, input logic [7:0] op,
                             input logic [3:0] fl, input int seq[4], input int n);
        cond_flags = fl;
        q_opcode   = op;
        q_valid    = 1'b1;
        #1;
        check({tag, " R2 pop"}, 32'(q_pop), 32'h1);
        check({tag, " R2 no ack"}, 32'(irq_ack), 32'h0);
        @(posedge clk); @(negedge clk);
        q_valid = 1'b0;
        follow(tag, seq, n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; q_valid = 1'b0; q_opcode = '0; irq_pend = 1'b0; cond_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 uaddr", 32'(uaddr), 32'h0);
        check_zero("R1");
        check("R1 pop", 32'(q_pop), 32'h0);
    endtask

    task automatic t_idle();
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            check("R11 idle pop", 32'(q_pop), 32'h0);
            check("R11 idle uaddr", 32'(uaddr), 32'h0);
            check_zero("R11 idle");
        end
    endtask

    task automatic t_irq_priority();
        q_valid = 1'b1; q_opcode = 8'h43; irq_pend = 1'b1;
        #1;
        check("R9 ack", 32'(irq_ack), 32'h1);
        check("R9 no pop", 32'(q_pop), 32'h0);
        @(posedge clk); @(negedge clk);
        irq_pend = 1'b0; q_valid = 1'b0;
        follow("R9 irq", '{48, 49, 0, 0}, 2);
        run_instr("R9 after irq", 8'h43, 4'h0, '{2, 3, 28, 29}, 4);
    endtask

    task automatic t_irq_mid();
        q_valid = 1'b1; q_opcode = 8'h43; cond_flags = '0;
        #1;
        check("R10 pop", 32'(q_pop), 32'h1);
        @(posedge clk); @(negedge clk);
        q_valid = 1'b0; irq_pend = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R10 held ack", 32'(irq_ack), 32'h0);
            @(posedge clk); @(negedge clk);
        end
        #1;
        check("R10 late ack", 32'(irq_ack), 32'h1);
        @(posedge clk); @(negedge clk);
        irq_pend = 1'b0;
        check("R10 vector", 32'(uaddr), 32'd48);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_share();
        q_valid = 1'b1; q_opcode = 8'h00; cond_flags = '0;
        @(posedge clk); @(negedge clk);
        q_valid = 1'b0;
        @(posedge clk); @(negedge clk);   // uaddr 16
        @(posedge clk); @(negedge clk);   // controls of 16
        en16 = reg_en; al16 = alu_sel;
        @(posedge clk); @(negedge clk);
        irq_pend = 1'b1;
        #1;
        @(posedge clk); @(negedge clk);   // uaddr 48
        irq_pend = 1'b0;
        @(posedge clk); @(negedge clk);   // controls of 48
        en48 = reg_en; al48 = alu_sel;
        check("R8 shared reg_en", 32'(en48), 32'(en16));
        check("R8 shared alu_sel", 32'(al48), 32'(al16));
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #1600000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        run_instr("R2 R3 mode0 op0", 8'h00, 4'h0, '{1, 16, 17, 0}, 3);
        run_instr("R2 R4 mode1 op3", 8'h43, 4'h0, '{2, 3, 28, 29}, 4);
        run_instr("R3 R4 jump mode2 op5", 8'hBD, 4'h0, '{4, 6, 36, 37}, 4);
        run_instr("R5 taken bit0", 8'hC1, 4'h1, '{8, 10, 20, 21}, 4);
        run_instr("R5 not taken bit0", 8'hC1, 4'hE, '{8, 9, 20, 21}, 4);
        run_instr("R5 taken bit2", 8'h07, 4'h4, '{1, 44, 47, 0}, 3);
        run_instr("R5 not taken bit2", 8'h07, 4'hB, '{1, 44, 45, 46}, 4);
        run_instr("R3 ignored mid bits", 8'h38, 4'h0, '{1, 16, 17, 0}, 3);
        t_irq_priority();
        t_irq_mid();
        t_share();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule